// File: doc/BRIEF.md
# Flash Status Flag Generator

This block produces the three status bits that a NOR flash device shows on its data bus while an internally timed program or erase runs. An upstream command decoder presents each recognised command as a one-cycle strobe with a command code. The strobe stands for the last write of the bus sequence, so the status bits become meaningful from the next clock. The block keeps an operation mode and counts abstract program or erase pulses from a pulse tick. It drives a toggle bit that inverts on every host read while the device is busy, a timeout bit that latches when the pulse count hits a limit, and an erase-timer bit that separates the sector-erase acceptance window from real erasing.

Protected targets get a fake busy period of fixed length, after which the block returns to read mode having changed nothing. When several sector-erase commands are queued in the window, erasing starts if at least one selected sector is unprotected. If all of them are protected, a longer fake busy period follows instead. A running erase can be suspended and resumed. A timeout can only be cleared by reset.

Top module: `flash_status_flags`

## Requirements
- R1: After a synchronous active-low reset, busy, toggle_bit, timeout_bit and erase_timer_bit are all 0.
- R2: While busy is 1, every rd_strobe cycle inverts toggle_bit once. While busy is 0, rd_strobe leaves toggle_bit unchanged.
- R3: An accepted program command (cmd_code 1) on an unprotected target sets busy from the next cycle. The PROG_PULSES-th pulse_tick returns the block to ready, and toggle_bit then stops changing.
- R4: A program command with tgt_protected=1 keeps busy at 1 for exactly PROG_FAKE_CYC cycles, and then the block returns to ready with timeout_bit 0 and no pulse_tick needed.
- R5: A sector-erase command (cmd_code 2) opens a window of WIN_CYC cycles in which busy is 1 and erase_timer_bit is 0. Each further sector-erase command in the window restarts it. When the window closes, erase_timer_bit rises.
- R6: A real erase, started from a window or by a chip-erase command (cmd_code 3) on an unprotected target, ends after ERASE_PULSES pulse_ticks. Busy and erase_timer_bit then return to 0.
- R7: A chip erase with tgt_protected=1, or a window in which every selected sector was protected, gives ERASE_FAKE_CYC busy cycles with erase_timer_bit 1. The block then returns to ready without erasing.
- R8: While a real erase runs, every command other than suspend is ignored.
- R9: Suspend (cmd_code 4) in a running erase and resume (cmd_code 5) in a suspended erase each invert toggle_bit once. While suspended, busy is 0 and pulse_ticks are not counted. After resume, the count continues from where it stopped.
- R10: When the pulse count reaches pulse_limit before the operation is done, timeout_bit becomes 1. Busy stays 1 and reads keep inverting toggle_bit until reset.
- R11: A program with tgt_nonblank=1 never completes and ends in the timeout condition.
- R12: In ready, codes other than 1, 2 and 3 are ignored. Inside the sector-erase window, codes other than 2 are ignored and do not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_code | input | 3 | 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| tgt_protected | input | 1 | Target sector of the command is protected |
| tgt_nonblank | input | 1 | Program target would need a 0-to-1 change |
| rd_strobe | input | 1 | One host read (chip-enable or output-enable edge) |
| pulse_tick | input | 1 | One internal program/erase pulse elapsed |
| pulse_limit | input | CNT_W | Pulse count at which the operation times out |
| toggle_bit | output | 1 | Toggle status bit |
| timeout_bit | output | 1 | Timing-limit-exceeded bit |
| erase_timer_bit | output | 1 | 0 in the sector-erase window, 1 once erasing starts |
| busy | output | 1 | 1 while an operation (real or fake) is in progress |

## Verification
A wrong mode shows at the ports within one cycle of the stimulus that should have moved it. Busy, erase_timer_bit or timeout_bit would disagree at the next sample. A stale interval or pulse count only shows when the window, the fake period or the pulse sequence ends, one cycle early or late. The bench sweeps pulse limits, read counts and interval lengths, so that any off-by-one in those counters changes busy at a sampled cycle. A toggle error persists once it happens, because toggle_bit is a running parity of the reads that were counted.

// File: rtl/fsf_pkg.sv
// Shared types for the flash status flag generator.
// Assumes command codes as listed in the brief; unknown codes decode to none.
package fsf_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_PROGRAM = 3'd1,
        CMD_SECTOR  = 3'd2,
        CMD_CHIP    = 3'd3,
        CMD_SUSPEND = 3'd4,
        CMD_RESUME  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        M_READY     = 3'd0,
        M_PROG      = 3'd1,
        M_PROG_FAKE = 3'd2,
        M_WINDOW    = 3'd3,
        M_ERASE     = 3'd4,
        M_SUSPEND   = 3'd5,
        M_ERASE_FAKE= 3'd6,
        M_FAIL      = 3'd7
    } mode_e;

endpackage

// File: rtl/fsf_interval_timer.sv
// Cycle counter for the window and fake-busy intervals.
// Assumes len >= 1 and that len is constant between clears.
// Expires in the last cycle of an interval of len cycles.
module fsf_interval_timer #(
    parameter int TMR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMR_W-1:0] len,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    // Expiry when the last cycle of the interval is reached.
    always_comb begin
        expire = run && (cnt == len - TMR_W'(1));
    end

    // Count cycles of the current interval; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= cnt + TMR_W'(1);
    end

    a_r5_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < len));

endmodule

// File: rtl/fsf_pulse_track.sv
// Counts internal program/erase pulses and reports completion or overrun.
// Assumes need >= 1. A blocked operation (non-blank program) never completes.
// Completion takes priority over overrun on the same pulse.
module fsf_pulse_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             blocked,
    input  logic [CNT_W-1:0] need,
    input  logic [CNT_W-1:0] limit,
    output logic             done,
    output logic             overrun
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    // Decide what the current pulse means for the operation.
    always_comb begin
        cnt_next = {1'b0, cnt} + (CNT_W+1)'(1);
        done     = count_en && !blocked && (cnt_next == {1'b0, need});
        overrun  = count_en && !done && (cnt_next >= {1'b0, limit});
    end

    // Accumulate pulses; hold the count across a suspend.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (clear)                      cnt <= '0;
        else if (count_en && !done && !overrun)
            cnt <= cnt_next[CNT_W-1:0];
    end

    a_r10_overrun_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clear) |=> $stable(cnt));

endmodule

// File: rtl/fsf_toggle.sv
// Toggle status bit: inverts on a read while busy and on suspend/resume events.
// Assumes at most one read strobe per cycle.
module fsf_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_strobe,
    input  logic susp_evt,
    output logic toggle_q
);
    logic flip;

    // A read in busy and a suspend/resume event each request one inversion.
    always_comb begin
        flip = (busy && rd_strobe) ^ susp_evt;
    end

    // Hold the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)    toggle_q <= 1'b0;
        else if (flip) toggle_q <= ~toggle_q;
    end

endmodule

// File: rtl/fsf_mode_ctrl.sv
// Operation mode controller: accepts commands, chooses real or fake operations,
// runs the sector-erase window and handles suspend, resume and failure.
// Assumes cmd_valid lasts one cycle per command and the target flags are valid with it.
module fsf_mode_ctrl
    import fsf_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int TMR_W          = 6,
    parameter int WIN_CYC        = 16,
    parameter int PROG_FAKE_CYC  = 8,
    parameter int ERASE_FAKE_CYC = 32,
    parameter int PROG_PULSES    = 3,
    parameter int ERASE_PULSES   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic             tgt_protected,
    input  logic             tgt_nonblank,
    input  logic             tmr_expire,
    input  logic             pulse_done,
    input  logic             pulse_over,
    output mode_e            mode,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic [TMR_W-1:0] tmr_len,
    output logic             pulse_clear,
    output logic             pulse_active,
    output logic             pulse_blocked,
    output logic [CNT_W-1:0] pulse_need,
    output logic             susp_evt,
    output logic             erase_started,
    output logic             busy
);
    cmd_e  cmd;
    mode_e mode_nx;
    logic  win_restart;
    logic  any_open_q, any_open_nx;
    logic  nb_q;
    logic  et_q;

    // Decode the incoming command, or none.
    always_comb begin
        cmd = cmd_valid ? cmd_e'(cmd_code) : CMD_NONE;
    end

    // Next mode and window bookkeeping.
    always_comb begin
        mode_nx     = mode;
        win_restart = 1'b0;
        any_open_nx = any_open_q;
        susp_evt    = 1'b0;
        case (mode)
            M_READY: begin
                case (cmd)
                    CMD_PROGRAM: mode_nx = tgt_protected ? M_PROG_FAKE : M_PROG;
                    CMD_SECTOR: begin
                        mode_nx     = M_WINDOW;
                        any_open_nx = !tgt_protected;
                    end
                    CMD_CHIP:    mode_nx = tgt_protected ? M_ERASE_FAKE : M_ERASE;
                    default:     mode_nx = M_READY;
                endcase
            end
            M_PROG: begin
                if (pulse_done)      mode_nx = M_READY;
                else if (pulse_over) mode_nx = M_FAIL;
            end
            M_PROG_FAKE: begin
                if (tmr_expire) mode_nx = M_READY;
            end
            M_WINDOW: begin
                if (cmd == CMD_SECTOR) begin
                    win_restart = 1'b0 | 1'b1;
                    any_open_nx = any_open_q || !tgt_protected;
                end else if (tmr_expire) begin
                    mode_nx = any_open_q ? M_ERASE : M_ERASE_FAKE;
                end
            end
            M_ERASE: begin
                if (pulse_done)              mode_nx = M_READY;
                else if (pulse_over)         mode_nx = M_FAIL;
                else if (cmd == CMD_SUSPEND) begin
                    mode_nx  = M_SUSPEND;
                    susp_evt = 1'b1;
                end
            end
            M_SUSPEND: begin
                if (cmd == CMD_RESUME) begin
                    mode_nx  = M_ERASE;
                    susp_evt = 1'b1;
                end
            end
            M_ERASE_FAKE: begin
                if (tmr_expire) mode_nx = M_READY;
            end
            default: mode_nx = M_FAIL;
        endcase
    end

    // Interval timer and pulse counter controls derived from the mode.
    always_comb begin
        tmr_clear     = (mode_nx != mode) || win_restart;
        tmr_run       = (mode == M_WINDOW) || (mode == M_PROG_FAKE) || (mode == M_ERASE_FAKE);
        case (mode)
            M_WINDOW:    tmr_len = TMR_W'(WIN_CYC);
            M_PROG_FAKE: tmr_len = TMR_W'(PROG_FAKE_CYC);
            default:     tmr_len = TMR_W'(ERASE_FAKE_CYC);
        endcase
        pulse_clear   = ((mode == M_READY) && (mode_nx == M_PROG)) ||
                        ((mode != M_SUSPEND) && (mode != M_ERASE) && (mode_nx == M_ERASE));
        pulse_active  = (mode == M_PROG) || (mode == M_ERASE);
        pulse_blocked = nb_q;
        pulse_need    = (mode == M_PROG) ? CNT_W'(PROG_PULSES) : CNT_W'(ERASE_PULSES);
        busy          = (mode != M_READY) && (mode != M_SUSPEND);
        erase_started = et_q;
    end

    // Mode register and the flag of an unprotected sector in the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= M_READY;
            any_open_q <= 1'b0;
        end else begin
            mode       <= mode_nx;
            any_open_q <= any_open_nx;
        end
    end

    // Non-blank program marker, captured when a pulse sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)           nb_q <= 1'b0;
        else if (pulse_clear) nb_q <= (mode_nx == M_PROG) && tgt_nonblank;
    end

    // Erase-timer flag: set once erasing (real or fake) begins, kept through failure.
    always_ff @(posedge clk) begin
        if (!rst_n) et_q <= 1'b0;
        else et_q <= (mode_nx == M_ERASE) || (mode_nx == M_SUSPEND) ||
                     (mode_nx == M_ERASE_FAKE) || ((mode_nx == M_FAIL) && et_q);
    end

    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FAIL) |=> (mode == M_FAIL));

    a_r8_erase_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ERASE) && cmd_valid && (cmd_code != 3'd4) && !pulse_done && !pulse_over)
        |=> (mode == M_ERASE));

    a_r5_window_timer_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WINDOW) |-> !et_q);

endmodule

// File: rtl/flash_status_flags.sv
// Top level of the flash status flag generator. It joins the mode controller,
// the interval timer, the pulse tracker and the toggle bit.
// Assumes one command, one read and one pulse at most per cycle.
module flash_status_flags
    import fsf_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int WIN_CYC        = 16,
    parameter int PROG_FAKE_CYC  = 8,
    parameter int ERASE_FAKE_CYC = 32,
    parameter int PROG_PULSES    = 3,
    parameter int ERASE_PULSES   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic             tgt_protected,
    input  logic             tgt_nonblank,
    input  logic             rd_strobe,
    input  logic             pulse_tick,
    input  logic [CNT_W-1:0] pulse_limit,
    output logic             toggle_bit,
    output logic             timeout_bit,
    output logic             erase_timer_bit,
    output logic             busy
);
    localparam int MAX_AB  = (WIN_CYC > PROG_FAKE_CYC) ? WIN_CYC : PROG_FAKE_CYC;
    localparam int MAX_CYC = (MAX_AB > ERASE_FAKE_CYC) ? MAX_AB : ERASE_FAKE_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    mode_e            mode;
    logic             tmr_clear, tmr_run, tmr_expire;
    logic [TMR_W-1:0] tmr_len;
    logic             pulse_clear, pulse_active, pulse_blocked;
    logic [CNT_W-1:0] pulse_need;
    logic             pulse_done, pulse_over;
    logic             susp_evt;

    fsf_mode_ctrl #(
        .CNT_W(CNT_W), .TMR_W(TMR_W), .WIN_CYC(WIN_CYC),
        .PROG_FAKE_CYC(PROG_FAKE_CYC), .ERASE_FAKE_CYC(ERASE_FAKE_CYC),
        .PROG_PULSES(PROG_PULSES), .ERASE_PULSES(ERASE_PULSES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tgt_protected(tgt_protected), .tgt_nonblank(tgt_nonblank),
        .tmr_expire(tmr_expire), .pulse_done(pulse_done), .pulse_over(pulse_over),
        .mode(mode), .tmr_clear(tmr_clear), .tmr_run(tmr_run), .tmr_len(tmr_len),
        .pulse_clear(pulse_clear), .pulse_active(pulse_active),
        .pulse_blocked(pulse_blocked), .pulse_need(pulse_need),
        .susp_evt(susp_evt), .erase_started(erase_timer_bit), .busy(busy)
    );

    fsf_interval_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run),
        .len(tmr_len), .expire(tmr_expire)
    );

    fsf_pulse_track #(.CNT_W(CNT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .clear(pulse_clear),
        .count_en(pulse_tick && pulse_active), .blocked(pulse_blocked),
        .need(pulse_need), .limit(pulse_limit),
        .done(pulse_done), .overrun(pulse_over)
    );

    fsf_toggle u_toggle (
        .clk(clk), .rst_n(rst_n), .busy(busy), .rd_strobe(rd_strobe),
        .susp_evt(susp_evt), .toggle_q(toggle_bit)
    );

    // Timeout bit is the failure mode seen at the bus.
    always_comb begin
        timeout_bit = (mode == M_FAIL);
    end

    a_r10_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_bit |-> busy);

    a_r2_idle_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(toggle_bit));

    a_r11_timeout_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_bit) |-> $past(pulse_tick));

endmodule

// File: tb/flash_status_flags_bench.sv
module flash_status_flags_bench;
    localparam int CW  = 6;
    localparam int WIN = 6;
    localparam int PF  = 4;
    localparam int EF  = 7;
    localparam int PP  = 3;
    localparam int EP  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic tgt_protected = 1'b0;
    logic tgt_nonblank = 1'b0;
    logic rd_strobe = 1'b0;
    logic pulse_tick = 1'b0;
    logic [CW-1:0] pulse_limit = CW'(40);
    logic toggle_bit, timeout_bit, erase_timer_bit, busy;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_status_flags #(
        .CNT_W(CW), .WIN_CYC(WIN), .PROG_FAKE_CYC(PF), .ERASE_FAKE_CYC(EF),
        .PROG_PULSES(PP), .ERASE_PULSES(EP)
    ) u_flash_status_flags (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tgt_protected(tgt_protected), .tgt_nonblank(tgt_nonblank),
        .rd_strobe(rd_strobe), .pulse_tick(pulse_tick), .pulse_limit(pulse_limit),
        .toggle_bit(toggle_bit), .timeout_bit(timeout_bit),
        .erase_timer_bit(erase_timer_bit), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int code, input bit prot, input bit nb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'(code);
        tgt_protected = prot; tgt_nonblank = nb;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd0; tgt_protected = 1'b0; tgt_nonblank = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); pulse_tick = 1'b1;
        @(negedge clk); pulse_tick = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit t0;
        do_reset();
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 toggle", toggle_bit, 0);
        chk("R1 timeout", timeout_bit, 0);
        chk("R1 erase_timer", erase_timer_bit, 0);

        // R2/R3: read-count sweep during a program
        for (int n = 0; n < 6; n++) begin
            do_reset();
            issue(1, 0, 0);
            chk("R3 busy after program", busy, 1);
            for (int i = 0; i < n; i++) rd();
            chk("R2 toggle parity", toggle_bit, n & 1);
            for (int i = 0; i < PP - 1; i++) tick();
            chk("R3 busy before last pulse", busy, 1);
            tick();
            chk("R3 ready after pulses", busy, 0);
            rd(); rd(); rd();
            chk("R2 no toggle in ready", toggle_bit, n & 1);
        end

        // R10: pulse-limit sweep for program and chip erase
        for (int lim = 0; lim < 8; lim++) begin
            do_reset();
            pulse_limit = CW'(lim);
            issue(1, 0, 0);
            for (int i = 0; i < PP; i++) tick();
            chk("R10 program timeout", timeout_bit, (lim < PP) ? 1 : 0);
            chk("R10 program busy", busy, (lim < PP) ? 1 : 0);
            do_reset();
            issue(3, 0, 0);
            for (int i = 0; i < EP; i++) tick();
            chk("R10 erase timeout", timeout_bit, (lim < EP) ? 1 : 0);
            chk("R6 erase busy", busy, (lim < EP) ? 1 : 0);
        end
        pulse_limit = CW'(40);

        // R10: failure is sticky and reads still toggle
        do_reset();
        pulse_limit = CW'(2);
        issue(1, 0, 0);
        tick(); tick();
        chk("R10 timeout set", timeout_bit, 1);
        t0 = toggle_bit;
        rd();
        chk("R10 toggle in failure", toggle_bit, !t0);
        idle(20); tick(); tick();
        chk("R10 still busy", busy, 1);
        chk("R10 still timeout", timeout_bit, 1);
        do_reset();
        chk("R1 reset clears timeout", timeout_bit, 0);
        pulse_limit = CW'(40);

        // R11: non-blank program reaches timeout instead of completing
        do_reset();
        pulse_limit = CW'(5);
        issue(1, 0, 1);
        for (int i = 0; i < PP; i++) tick();
        chk("R11 not done after normal pulses", busy, 1);
        chk("R11 no timeout yet", timeout_bit, 0);
        tick(); tick();
        chk("R11 timeout", timeout_bit, 1);
        pulse_limit = CW'(40);

        // R4: protected program fake busy
        do_reset();
        issue(1, 1, 0);
        idle(PF - 1);
        chk("R4 busy last fake cycle", busy, 1);
        idle(1);
        chk("R4 ready after fake", busy, 0);
        chk("R4 no timeout", timeout_bit, 0);

        // R5/R6: sector window then real erase
        do_reset();
        issue(2, 0, 0);
        chk("R5 busy in window", busy, 1);
        idle(WIN - 1);
        chk("R5 timer low end of window", erase_timer_bit, 0);
        idle(1);
        chk("R5 timer high after window", erase_timer_bit, 1);
        for (int i = 0; i < EP; i++) tick();
        chk("R6 erase done", busy, 0);
        chk("R6 timer cleared", erase_timer_bit, 0);

        // R5: restart of the window by another sector erase
        do_reset();
        issue(2, 1, 0);
        idle(2);
        issue(2, 0, 0);
        idle(WIN - 1);
        chk("R5 restarted window low", erase_timer_bit, 0);
        idle(1);
        chk("R5 restarted window high", erase_timer_bit, 1);
        idle(EF + 2);
        chk("R5 mixed window is real erase", busy, 1);

        // R12: program inside window ignored, window not restarted
        do_reset();
        issue(2, 0, 0);
        idle(1);
        issue(1, 0, 0);
        idle(WIN - 3);
        chk("R12 window end unchanged", erase_timer_bit, 1);

        // R7: all-protected window, and protected chip erase
        for (int k = 0; k < 2; k++) begin
            do_reset();
            if (k == 0) begin
                issue(2, 1, 0); issue(2, 1, 0);
                idle(WIN - 1);
                idle(1);
            end else begin
                issue(3, 1, 0);
            end
            chk("R7 fake timer high", erase_timer_bit, 1);
            idle(EF - 1);
            chk("R7 busy last fake cycle", busy, 1);
            idle(1);
            chk("R7 ready after fake", busy, 0);
            chk("R7 timer cleared", erase_timer_bit, 0);
        end

        // R8: commands ignored during erase
        do_reset();
        issue(3, 0, 0);
        tick();
        issue(1, 0, 0); issue(2, 0, 0); issue(5, 0, 0);
        for (int i = 0; i < EP - 1; i++) tick();
        chk("R8 erase ends on schedule", busy, 0);
        chk("R8 no program started", erase_timer_bit, 0);

        // R9: suspend and resume
        do_reset();
        issue(3, 0, 0);
        tick(); tick();
        t0 = toggle_bit;
        issue(4, 0, 0);
        chk("R9 suspend flips toggle", toggle_bit, !t0);
        chk("R9 not busy suspended", busy, 0);
        chk("R9 timer kept", erase_timer_bit, 1);
        tick(); tick(); tick(); rd();
        chk("R9 no toggle on read suspended", toggle_bit, !t0);
        issue(5, 0, 0);
        chk("R9 resume flips toggle", toggle_bit, t0);
        chk("R9 busy after resume", busy, 1);
        tick();
        chk("R9 count retained", busy, 1);
        tick();
        chk("R9 done after remaining pulses", busy, 0);

        // R12: suspend in ready ignored
        do_reset();
        issue(4, 0, 0); issue(6, 0, 0);
        chk("R12 ready ignores code", busy, 0);
        chk("R12 toggle unchanged", toggle_bit, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule